// File: doc/BRIEF.md
# Banked Three-Wire Serial Register Interface

This block is the device side of a three-wire control bus made of a host-driven strobe clock, a direction line and one data line. The host shifts in an 8-bit address and then either shifts in 8 data bits or turns the direction line around and clocks 8 bits back out. Behind the address sits a register space split into three banks. A bank-select register at address 01h appears in every bank and picks the bank used by later accesses. Write-only control registers are held per bank and presented to the rest of the chip as one flat vector. A small set of read-only identity and status bytes are assembled from status inputs.

The data line is modelled as three pad-side signals: the incoming level, the outgoing level and an output enable. The enable is active only while the device returns read data or while the data pin has been turned into an interrupt output. All bus inputs are taken as already synchronous to the system clock. The strobe is edge-detected in that domain, so each strobe half-period must last at least two system clocks.

Top module: `tw_bank_regs`

## Requirements
- R1: A write frame is 16 strobe rising edges with `rw_sel` high: 8 address bits and then 8 data bits, MSB first, each taken from `data_in` at the rising edge. The write takes effect on the 16th edge.
- R2: After reset `bank` is 1. A write to address 01h in any bank with data 01h, 02h or 03h selects that bank. Any other data value leaves the bank unchanged.
- R3: Writable slots are, in bank 1: 02h–06h, 08h and 09h; in bank 2: 02h–0Bh; in bank 3: 02h–04h. Slot (bank, addr) appears on `ctrl_regs[((bank-1)*16+addr)*8 +: 8]`. All slots reset to 00h, and the vector changes only on a completed write.
- R4: Writes to any other address, including the read-only ones and addresses with a nonzero upper nibble, change no register and no bank.
- R5: A read frame is 8 address bits with `rw_sel` high, then a falling edge of `rw_sel`. From the next clock `data_oe` is 1 and `data_out` shows bit 7. Each later strobe rising edge advances one bit. After the 8th edge `data_oe` returns to 0.
- R6: Bank 1 address 00h reads 07h.
- R7: In bank 1, 0Ah and 0Bh return the low and high bytes of `meas_count`. 0Ch returns {4'hD, 2'b11, `ovf_flag`, `afc_flag`}. 0Dh returns `station_stat`. 0Eh returns {2'b11, `flag_cnt`, 1'b0, `flag_afc`, 2'b00, `flag_fs`}.
- R8: Reads of write-only, undefined, or bank 2 and bank 3 addresses return 00h.
- R9: Writing any value to bank 1 address 0Fh enters interrupt-output mode. In that mode `data_oe` is 1 and `data_out` = `irq_in` XOR bit 3 of bank 1 slot 08h (bit 3 = 1 gives an active-low pin).
- R10: Interrupt-output mode ends on the next strobe rising edge. That edge is consumed and is not counted as a frame bit.
- R11: `data_oe` is 0 whenever neither a read data phase nor interrupt-output mode is active.
- R12: Strobe rising edges seen with `rw_sel` low during the address phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Host strobe clock |
| rw_sel | input | 1 | High: host writes; low: device drives read data |
| data_in | input | 1 | Level seen on the data pin |
| data_out | output | 1 | Level driven onto the data pin |
| data_oe | output | 1 | Data pin output enable |
| irq_in | input | 1 | Combined interrupt request from the chip |
| meas_count | input | 16 | Measurement counter value |
| ovf_flag | input | 1 | Counter overflow status |
| afc_flag | input | 1 | Frequency-control out-of-range status |
| station_stat | input | 8 | Station stereo and field-strength status |
| flag_cnt | input | 1 | Count-done interrupt flag |
| flag_afc | input | 1 | Frequency-control interrupt flag |
| flag_fs | input | 1 | Field-strength or mono/stereo change flag |
| bank | output | 2 | Currently selected bank |
| ctrl_regs | output | 384 | All 48 register slots, 8 bits each |

## Verification
On every cycle the assertions check that the bank never leaves 1..3, that the register vector moves only on a completed write, and that a read turn-on follows a direction-line fall. They also check that interrupt mode is left on the first strobe edge and that low-direction strobes do not shift the address. The bench's scenarios are needed for the content of reads, bit by bit, for which slots accept writes, and for rejected bank numbers. They also show the interrupt polarity and that frame alignment survives ignored and consumed strobes. A behavioural model compares the pin, bank and register vector every clock.

// File: rtl/tw_bank_regs.sv
module tw_bank_regs #(
  parameter int NBANK = 3,
  parameter int NSLOT = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk,
  input  logic                     rw_sel,
  input  logic                     data_in,
  output logic                     data_out,
  output logic                     data_oe,
  input  logic                     irq_in,
  input  logic [15:0]              meas_count,
  input  logic                     ovf_flag,
  input  logic                     afc_flag,
  input  logic [7:0]               station_stat,
  input  logic                     flag_cnt,
  input  logic                     flag_afc,
  input  logic                     flag_fs,
  output logic [1:0]               bank,
  output logic [NBANK*NSLOT*8-1:0] ctrl_regs
);
  localparam int NREG = NBANK * NSLOT;
  localparam int IW   = $clog2(NREG);

  typedef enum logic [1:0] {PH_ADDR, PH_DATA, PH_RD} phase_t;

  phase_t     phase;
  logic [2:0] cnt;
  logic [7:0] shreg, addr_q, rd_val;
  logic       ser_q, rw_q, irq_mode;
  logic [7:0] rf [NREG];

  wire        ser_rise  = ser_clk & ~ser_q;
  wire        rw_fall   = ~rw_sel & rw_q;
  wire [7:0]  shin      = {shreg[6:0], data_in};
  wire        rd_active = (phase == PH_RD);
  wire        ph_addr   = (phase == PH_ADDR);
  wire        wr_commit = ~irq_mode & (phase == PH_DATA) & ser_rise & rw_sel & (cnt == 3'd7);
  wire [IW-1:0] widx    = IW'({bank - 2'd1, addr_q[3:0]});

  function automatic logic wr_ok(input logic [1:0] b, input logic [7:0] a);
    if (a[7:4] != 4'd0) return 1'b0;
    case (b)
      2'd1:    return (a[3:0] >= 4'd2 && a[3:0] <= 4'd6) || a[3:0] == 4'd8 || a[3:0] == 4'd9;
      2'd2:    return a[3:0] >= 4'd2 && a[3:0] <= 4'd11;
      2'd3:    return a[3:0] >= 4'd2 && a[3:0] <= 4'd4;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    rd_val = 8'h00;
    if (bank == 2'd1 && addr_q[7:4] == 4'd0) begin
      case (addr_q[3:0])
        4'h0:    rd_val = 8'h07;
        4'hA:    rd_val = meas_count[7:0];
        4'hB:    rd_val = meas_count[15:8];
        4'hC:    rd_val = {4'hD, 2'b11, ovf_flag, afc_flag};
        4'hD:    rd_val = station_stat;
        4'hE:    rd_val = {2'b11, flag_cnt, 1'b0, flag_afc, 2'b00, flag_fs};
        default: rd_val = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_ADDR;
      cnt      <= 3'd0;
      shreg    <= 8'h00;
      addr_q   <= 8'h00;
      irq_mode <= 1'b0;
      ser_q    <= 1'b0;
      rw_q     <= 1'b0;
    end else begin
      ser_q <= ser_clk;
      rw_q  <= rw_sel;
      if (irq_mode) begin
        if (ser_rise) irq_mode <= 1'b0;
      end else begin
        case (phase)
          PH_ADDR: if (ser_rise && rw_sel) begin
            shreg <= shin;
            if (cnt == 3'd7) begin
              addr_q <= shin;
              phase  <= PH_DATA;
              cnt    <= 3'd0;
            end else cnt <= cnt + 3'd1;
          end
          PH_DATA: if (rw_fall && cnt == 3'd0) begin
            shreg <= rd_val;
            phase <= PH_RD;
          end else if (ser_rise && rw_sel) begin
            shreg <= shin;
            if (cnt == 3'd7) begin
              phase <= PH_ADDR;
              cnt   <= 3'd0;
              if (bank == 2'd1 && addr_q == 8'h0F) irq_mode <= 1'b1;
            end else cnt <= cnt + 3'd1;
          end
          PH_RD: if (ser_rise) begin
            shreg <= {shreg[6:0], 1'b0};
            if (cnt == 3'd7) begin
              phase <= PH_ADDR;
              cnt   <= 3'd0;
            end else cnt <= cnt + 3'd1;
          end
          default: phase <= PH_ADDR;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank <= 2'd1;
      for (int i = 0; i < NREG; i++) rf[i] <= 8'h00;
    end else if (wr_commit) begin
      if (addr_q == 8'h01) begin
        if (shin == 8'h01 || shin == 8'h02 || shin == 8'h03) bank <= shin[1:0];
      end else if (wr_ok(bank, addr_q)) begin
        rf[widx] <= shin;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign ctrl_regs[g*8 +: 8] = rf[g];
  end

  assign data_oe  = irq_mode | rd_active;
  assign data_out = irq_mode ? (irq_in ^ rf[8][3]) : shreg[7];
endmodule

// File: rtl/tw_bank_regs_chk.sv
module tw_bank_regs_chk #(
  parameter int W = 384
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rw_sel,
  input logic         data_oe,
  input logic         rd_active,
  input logic         irq_mode,
  input logic         ser_rise,
  input logic         ph_addr,
  input logic         wr_commit,
  input logic [1:0]   bank,
  input logic [7:0]   shreg,
  input logic [W-1:0] ctrl_regs
);
  a_r2_bank_valid: assert property (@(posedge clk) disable iff (!rst_n)
    bank != 2'd0);

  a_r3_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(ctrl_regs));

  a_r5_read_turn: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(data_oe) && rd_active) |-> ($past(rw_sel, 2) && !$past(rw_sel)));

  a_r10_irq_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode && ser_rise) |=> !irq_mode);

  a_r12_low_dir_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_addr && !irq_mode && ser_rise && !rw_sel) |=> $stable(shreg));
endmodule

bind tw_bank_regs tw_bank_regs_chk #(.W(NBANK*NSLOT*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .rw_sel(rw_sel), .data_oe(data_oe),
  .rd_active(rd_active), .irq_mode(irq_mode), .ser_rise(ser_rise),
  .ph_addr(ph_addr), .wr_commit(wr_commit), .bank(bank),
  .shreg(shreg), .ctrl_regs(ctrl_regs)
);

// File: tb/tb_tw_bank_regs.sv
module tb_tw_bank_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, ser_clk = 0, rw_sel = 1, data_in = 0, irq_in = 0;
  logic [15:0] meas_count = 16'hBEEF;
  logic ovf_flag = 1, afc_flag = 0, flag_cnt = 1, flag_afc = 1, flag_fs = 0;
  logic [7:0] station_stat = 8'h8F;
  logic data_out, data_oe;
  logic [1:0] bank;
  logic [383:0] ctrl_regs;

  int checks = 0, errors = 0;

  logic [1:0] m_bank = 2'd1;
  logic [7:0] m_rf [48];
  bit m_irq = 0, exp_rd_oe = 0;
  logic [7:0] exp_rd = 8'h00;

  tw_bank_regs dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .rw_sel(rw_sel),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .irq_in(irq_in),
    .meas_count(meas_count), .ovf_flag(ovf_flag), .afc_flag(afc_flag),
    .station_stat(station_stat), .flag_cnt(flag_cnt), .flag_afc(flag_afc),
    .flag_fs(flag_fs), .bank(bank), .ctrl_regs(ctrl_regs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [383:0] act, input logic [383:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic bit m_wr_ok(input int b, input int a);
    if (b == 1) return (a >= 2 && a <= 6) || a == 8 || a == 9;
    if (b == 2) return a >= 2 && a <= 11;
    if (b == 3) return a >= 2 && a <= 4;
    return 0;
  endfunction

  function automatic logic [383:0] m_flat();
    logic [383:0] f;
    for (int i = 0; i < 48; i++) f[i*8 +: 8] = m_rf[i];
    return f;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h01) begin
      if (d >= 8'h01 && d <= 8'h03) m_bank = d[1:0];
    end else if (a == 8'h0F && m_bank == 2'd1) m_irq = 1;
    else if (m_wr_ok(int'(m_bank), int'(a))) m_rf[(int'(m_bank) - 1) * 16 + int'(a)] = d;
  endtask

  task automatic pulse_ser(input bit irq_exit);
    @(negedge clk) ser_clk = 1;
    if (irq_exit) m_irq = 0;
    repeat (2) @(negedge clk);
    ser_clk = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    logic [15:0] fr;
    fr = {a, d};
    @(negedge clk) rw_sel = 1;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk) data_in = fr[i];
      repeat (2) @(negedge clk);
      ser_clk = 1;
      if (i == 0) model_write(a, d);
      repeat (2) @(negedge clk);
      ser_clk = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic read_reg(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk) rw_sel = 1;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) data_in = a[i];
      repeat (2) @(negedge clk);
      ser_clk = 1;
      repeat (2) @(negedge clk);
      ser_clk = 0;
    end
    @(negedge clk) rw_sel = 0;
    exp_rd = exp;
    exp_rd_oe = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk(req, 384'(data_out), 384'(exp[7-i]));
      ser_clk = 1;
      exp_rd = {exp_rd[6:0], 1'b0};
      if (i == 7) exp_rd_oe = 0;
      repeat (2) @(negedge clk);
      ser_clk = 0;
      repeat (2) @(negedge clk);
    end
    rw_sel = 1;
    repeat (2) @(negedge clk);
  endtask

  // every-cycle comparison against the model (R2, R3, R5, R9, R11)
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R11 oe", 384'(data_oe), 384'(m_irq | exp_rd_oe));
      if (m_irq) chk("R9 irq pin", 384'(data_out), 384'(irq_in ^ m_rf[8][3]));
      else if (exp_rd_oe) chk("R5 read bit", 384'(data_out), 384'(exp_rd[7]));
      chk("R2 bank", 384'(bank), 384'(m_bank));
      chk("R3 regs", ctrl_regs, m_flat());
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 48; i++) m_rf[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset bank", 384'(bank), 384'd1);
    chk("R3 reset regs", ctrl_regs, 384'd0);
    chk("R11 reset oe", 384'(data_oe), 384'd0);

    // R1 R3: bank 1 writes
    write_reg(8'h02, 8'hA5);
    write_reg(8'h09, 8'h3C);
    write_reg(8'h08, 8'h08);
    chk("R1 slot 02", 384'(ctrl_regs[2*8 +: 8]), 384'hA5);
    chk("R3 slot 09", 384'(ctrl_regs[9*8 +: 8]), 384'h3C);

    // R6 R7 R8 reads
    read_reg(8'h00, 8'h07, "R6 id");
    read_reg(8'h0A, 8'hEF, "R7 cnt lo");
    read_reg(8'h0B, 8'hBE, "R7 cnt hi");
    read_reg(8'h0C, 8'hDE, "R7 ctrl stat");
    read_reg(8'h0D, 8'h8F, "R7 station");
    read_reg(8'h0E, 8'hE8, "R7 irq id");
    read_reg(8'h02, 8'h00, "R8 write-only");
    read_reg(8'h07, 8'h00, "R8 undefined");

    // R4 ignored writes
    write_reg(8'h07, 8'h55);
    write_reg(8'h00, 8'h66);
    write_reg(8'h12, 8'h77);
    chk("R4 no change", ctrl_regs, m_flat());

    // R2 invalid and valid bank numbers
    write_reg(8'h01, 8'h05);
    chk("R2 bad bank", 384'(bank), 384'd1);
    write_reg(8'h01, 8'h00);
    chk("R2 zero bank", 384'(bank), 384'd1);
    write_reg(8'h01, 8'h02);
    chk("R2 bank2", 384'(bank), 384'd2);
    for (int a = 2; a <= 12; a++) write_reg(8'(a), 8'(8'h40 + a));
    chk("R3 bank2 slot 0B", 384'(ctrl_regs[(16+11)*8 +: 8]), 384'h4B);
    chk("R4 bank2 slot 0C", 384'(ctrl_regs[(16+12)*8 +: 8]), 384'h00);
    read_reg(8'h00, 8'h00, "R8 bank2 read");
    write_reg(8'h0F, 8'h01);
    chk("R9 no irq in bank2", 384'(data_oe), 384'd0);

    write_reg(8'h01, 8'h03);
    for (int a = 2; a <= 5; a++) write_reg(8'(a), 8'(8'h90 + a));
    chk("R3 bank3 slot 04", 384'(ctrl_regs[(32+4)*8 +: 8]), 384'h94);
    chk("R4 bank3 slot 05", 384'(ctrl_regs[(32+5)*8 +: 8]), 384'h00);
    read_reg(8'h0C, 8'h00, "R8 bank3 read");
    write_reg(8'h01, 8'h01);
    chk("R2 back to bank1", 384'(bank), 384'd1);

    // R12 low-direction strobes ignored in address phase
    @(negedge clk) rw_sel = 0;
    pulse_ser(0);
    pulse_ser(0);
    pulse_ser(0);
    @(negedge clk) rw_sel = 1;
    write_reg(8'h03, 8'h5A);
    chk("R12 alignment kept", 384'(ctrl_regs[3*8 +: 8]), 384'h5A);

    // R9 R10 interrupt output mode, active low (slot 08h bit 3 set)
    write_reg(8'h0F, 8'hFF);
    @(negedge clk);
    chk("R9 oe on", 384'(data_oe), 384'd1);
    chk("R9 idle level", 384'(data_out), 384'd1);
    irq_in = 1;
    repeat (2) @(negedge clk);
    chk("R9 active level", 384'(data_out), 384'd0);
    irq_in = 0;
    pulse_ser(1);
    chk("R10 released", 384'(data_oe), 384'd0);
    write_reg(8'h04, 8'hC3);
    chk("R10 edge consumed", 384'(ctrl_regs[4*8 +: 8]), 384'hC3);

    // R9 active-high polarity
    write_reg(8'h08, 8'h00);
    write_reg(8'h0F, 8'h00);
    irq_in = 1;
    repeat (2) @(negedge clk);
    chk("R9 active high", 384'(data_out), 384'd1);
    irq_in = 0;
    pulse_ser(1);
    read_reg(8'h00, 8'h07, "R5 read after irq");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule